// File: doc/BRIEF.md
# Program Counter and Instruction Fetch Stage

This block is the front end of a small two-stage 8-bit RISC core. It keeps a 9-bit word program counter over a 512-word program store of 16-bit words. While the execute stage works on one instruction, this block already has the next one in flight, so one instruction leaves the fetch register every clock. The program store is a synchronous read port owned by the surrounding chip: an address presented in one cycle returns its word in the next cycle.

The execute stage drives three controls back into the block. A relative redirect moves execution to the address of the instruction now in the fetch register, plus a signed 12-bit offset, plus one. The wrong-path word behind the jump is replaced by an all-zero no-op, so a taken jump costs two cycles. A constant read uses the program port for one cycle to fetch one byte, chosen by a 16-bit byte pointer, and returns it with a one-cycle strobe. A stall freezes the whole stage. The reset is synchronous and active high.

Top module: `pfetch_unit`

## Requirements
- R1: While `rst` is high, and on the first clock after it falls, `instr_valid` and `cread_valid` are 0 and `imem_addr` is 0. The word returned in the first cycle after reset is never presented. The instruction at address 0 appears, valid, two clocks after `rst` falls.
- R2: Without stalls, redirects or constant reads, each clock presents the next word: `instr_pc` steps by one modulo 512 (511 is followed by 0), and `instr` equals the memory word at `instr_pc`.
- R3: With `instr_valid` = 1, `redir_req` = 1 and `stall` = 0, the target is (`instr_pc` + sign-extended `redir_ofs` + 1) modulo 512, with `redir_ofs` in two's complement (-2048..2047). It is driven on `imem_addr` in that same cycle, and the target instruction is presented, valid, two clocks later.
- R4: In the clock after a taken redirect, `instr_valid` is 0 and `instr` is 16'h0000, the no-op.
- R5: `redir_req` has no effect while `instr_valid` is 0. The instruction stream continues unchanged.
- R6: While `stall` is 1, `instr`, `instr_pc` and `instr_valid` hold their values, `cread_valid` stays 0, and `redir_req` and `cread_req` are ignored. After the stall, fetching resumes at the next word with no word lost.
- R7: A constant read (`cread_req` = 1, `stall` = 0, no taken redirect) drives word address `cread_ptr[9:1]` on `imem_addr`. Two clocks later `cread_valid` is 1 for exactly one clock, and `cread_data` is the high byte of that word when `cread_ptr[0]` = 1, or the low byte when it is 0. The program counter holds for that cycle, so the instruction stream shows one invalid no-op slot, which coincides with the strobe.
- R8: A constant read whose pointer has any of bits 15..10 set lies outside the 512-word store. It still produces the strobe, with `cread_data` = 8'h00.
- R9: When a taken redirect and `cread_req` occur in the same cycle, the redirect is performed and the constant read is dropped: no `cread_valid` follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, undivided |
| rst | input | 1 | Synchronous reset, active high |
| stall | input | 1 | Freeze the fetch stage for this cycle |
| redir_req | input | 1 | Relative jump/call from the instruction in the fetch register |
| redir_ofs | input | 12 | Signed word offset of the redirect |
| cread_req | input | 1 | Constant byte read request |
| cread_ptr | input | 16 | Byte pointer of the constant read |
| imem_rdata | input | 16 | Program word returned one clock after its address |
| imem_addr | output | 9 | Word address to the program store |
| instr | output | 16 | Fetched instruction (0x0000 when invalid) |
| instr_pc | output | 9 | Word address of `instr` |
| instr_valid | output | 1 | `instr` is a real fetched instruction |
| cread_data | output | 8 | Byte returned by a constant read |
| cread_valid | output | 1 | One-clock strobe marking `cread_data` |

## Verification
Straight-line fetch runs across the 511-to-0 boundary, which separates a correct modulo-512 counter from a saturating or wider one. Redirects use offsets +5, -1, -2048 and +2047, plus one offset that lands near the top of memory. The -1 offset re-executes the jump itself, and the two extreme offsets wrap exactly to the next and the current address. These cases expose a missing "+1", a sign-extension error or an off-by-one in the target, and the no-op slot after each redirect shows whether the wrong-path word is discarded. Constant reads cover an even pointer, an odd pointer, the last byte of memory and an out-of-range pointer, which tell byte-select swaps and address shifts apart. Stalls with a redirect or a constant read held across them, a redirect during the no-op slot, and a redirect that collides with a constant read check the priority order.

// File: rtl/pfetch_pkg.sv
package pfetch_pkg;

    // Source of the word address driven to the program store this cycle
    typedef enum logic [1:0] {
        SRC_SEQ   = 2'd0,   // sequential program counter
        SRC_HOLD  = 2'd1,   // re-issue the word in flight (stall)
        SRC_JUMP  = 2'd2,   // relative redirect target
        SRC_CONST = 2'd3    // constant byte read
    } src_e;

endpackage

// File: rtl/pfetch_target.sv
module pfetch_target #(
    parameter int PC_W  = 9,
    parameter int OFS_W = 12
) (
    input  logic [PC_W-1:0]  base,
    input  logic [OFS_W-1:0] ofs,
    output logic [PC_W-1:0]  target
);
    localparam int SUM_W = ((PC_W > OFS_W) ? PC_W : OFS_W) + 1;

    logic [SUM_W-1:0] base_x;
    logic [SUM_W-1:0] ofs_x;
    logic [SUM_W-1:0] sum;

    always_comb begin
        base_x = {{(SUM_W-PC_W){1'b0}}, base};
        ofs_x  = {{(SUM_W-OFS_W){ofs[OFS_W-1]}}, ofs};
        sum    = base_x + ofs_x + SUM_W'(1);
        target = sum[PC_W-1:0];
    end
endmodule

// File: rtl/pfetch_issue_mux.sv
module pfetch_issue_mux
    import pfetch_pkg::*;
#(
    parameter int PC_W = 9
) (
    input  src_e            src,
    input  logic [PC_W-1:0] seq_addr,
    input  logic [PC_W-1:0] hold_addr,
    input  logic [PC_W-1:0] jump_addr,
    input  logic [PC_W-1:0] const_addr,
    output logic [PC_W-1:0] addr
);
    always_comb begin
        unique case (src)
            SRC_HOLD:  addr = hold_addr;
            SRC_JUMP:  addr = jump_addr;
            SRC_CONST: addr = const_addr;
            default:   addr = seq_addr;
        endcase
    end
endmodule

// File: rtl/pfetch_byte_pick.sv
module pfetch_byte_pick #(
    parameter int INSTR_W = 16
) (
    input  logic [INSTR_W-1:0]   word,
    input  logic                 sel,
    input  logic                 blank,
    output logic [INSTR_W/2-1:0] lane_out
);
    localparam int BYTE_W = INSTR_W / 2;

    logic [BYTE_W-1:0] lane [2];

    for (genvar g = 0; g < 2; g++) begin : g_lane
        assign lane[g] = word[g*BYTE_W +: BYTE_W];
    end

    assign lane_out = blank ? '0 : lane[sel];
endmodule

// File: rtl/pfetch_unit.sv
module pfetch_unit
    import pfetch_pkg::*;
#(
    parameter int PC_W    = 9,
    parameter int INSTR_W = 16,
    parameter int OFS_W   = 12,
    parameter int PTR_W   = 16,
    localparam int BYTE_W = INSTR_W / 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               stall,
    input  logic               redir_req,
    input  logic [OFS_W-1:0]   redir_ofs,
    input  logic               cread_req,
    input  logic [PTR_W-1:0]   cread_ptr,
    input  logic [INSTR_W-1:0] imem_rdata,
    output logic [PC_W-1:0]    imem_addr,
    output logic [INSTR_W-1:0] instr,
    output logic [PC_W-1:0]    instr_pc,
    output logic               instr_valid,
    output logic [BYTE_W-1:0]  cread_data,
    output logic               cread_valid
);
    typedef struct packed {
        logic [PC_W-1:0]    pc;          // next sequential fetch address
        logic [INSTR_W-1:0] ir;          // fetch register
        logic [PC_W-1:0]    ir_pc;
        logic               ir_valid;
        logic               pend_valid;  // a word returns this cycle
        logic               pend_cread;  // ... and it belongs to a constant read
        logic               pend_sel;
        logic               pend_oor;
        logic [PC_W-1:0]    pend_addr;
        logic [BYTE_W-1:0]  cdata;
        logic               cvalid;
    } state_t;

    state_t q, d;

    logic            take_redir;
    logic            take_cread;
    src_e            src;
    logic [PC_W-1:0] jump_addr;
    logic [PC_W-1:0] const_addr;
    logic            const_oor;
    logic [PC_W-1:0] issue_addr;
    logic [BYTE_W-1:0] picked;

    assign take_redir = redir_req && q.ir_valid && !stall;
    assign take_cread = cread_req && !stall && !take_redir;
    assign const_addr = cread_ptr[PC_W:1];
    assign const_oor  = |cread_ptr[PTR_W-1:PC_W+1];

    always_comb begin
        if (stall)           src = SRC_HOLD;
        else if (take_redir) src = SRC_JUMP;
        else if (take_cread) src = SRC_CONST;
        else                 src = SRC_SEQ;
    end

    pfetch_target #(.PC_W(PC_W), .OFS_W(OFS_W)) u_target (
        .base   (q.ir_pc),
        .ofs    (redir_ofs),
        .target (jump_addr)
    );

    pfetch_issue_mux #(.PC_W(PC_W)) u_mux (
        .src        (src),
        .seq_addr   (q.pc),
        .hold_addr  (q.pend_addr),
        .jump_addr  (jump_addr),
        .const_addr (const_addr),
        .addr       (issue_addr)
    );

    pfetch_byte_pick #(.INSTR_W(INSTR_W)) u_pick (
        .word     (imem_rdata),
        .sel      (q.pend_sel),
        .blank    (q.pend_oor),
        .lane_out (picked)
    );

    always_comb begin
        d = q;
        d.cvalid = 1'b0;
        if (!stall) begin
            // retire the word returning now
            if (q.pend_valid && q.pend_cread) begin
                d.cdata    = picked;
                d.cvalid   = 1'b1;
                d.ir       = '0;
                d.ir_valid = 1'b0;
            end else if (q.pend_valid && !take_redir) begin
                d.ir       = imem_rdata;
                d.ir_pc    = q.pend_addr;
                d.ir_valid = 1'b1;
            end else begin
                d.ir       = '0;
                d.ir_valid = 1'b0;
            end
            // record the word issued now
            d.pend_valid = 1'b1;
            d.pend_cread = take_cread;
            d.pend_sel   = cread_ptr[0];
            d.pend_oor   = take_cread && const_oor;
            d.pend_addr  = issue_addr;
            d.pc         = take_cread ? q.pc : issue_addr + PC_W'(1);
        end
        if (rst) begin
            d = '0;
        end
    end

    always_ff @(posedge clk) begin
        q <= d;
    end

    assign imem_addr   = issue_addr;
    assign instr       = q.ir;
    assign instr_pc    = q.ir_pc;
    assign instr_valid = q.ir_valid;
    assign cread_data  = q.cdata;
    assign cread_valid = q.cvalid;
endmodule

// File: rtl/pfetch_unit_chk.sv
module pfetch_unit_chk #(
    parameter int PC_W    = 9,
    parameter int INSTR_W = 16,
    parameter int OFS_W   = 12
) (
    input logic               clk,
    input logic               rst,
    input logic               stall,
    input logic               redir_req,
    input logic [OFS_W-1:0]   redir_ofs,
    input logic [PC_W-1:0]    imem_addr,
    input logic [INSTR_W-1:0] instr,
    input logic [PC_W-1:0]    instr_pc,
    input logic               instr_valid,
    input logic               cread_valid
);
    localparam int XW = PC_W + OFS_W + 1;

    logic [XW-1:0]   pc_ext;
    logic [XW-1:0]   ofs_ext;
    logic [XW-1:0]   sum_ext;
    logic [PC_W-1:0] exp_tgt;

    always_comb begin
        pc_ext  = {{(XW-PC_W){1'b0}}, instr_pc};
        ofs_ext = {{(XW-OFS_W){redir_ofs[OFS_W-1]}}, redir_ofs};
        sum_ext = pc_ext + ofs_ext + XW'(1);
        exp_tgt = sum_ext[PC_W-1:0];
    end

    AST_REDIR_ADDR: assert property (@(posedge clk) disable iff (rst)
        (redir_req && instr_valid && !stall) |-> (imem_addr == exp_tgt)); // R3

    AST_REDIR_SQUASH: assert property (@(posedge clk) disable iff (rst)
        (redir_req && instr_valid && !stall) |=> (!instr_valid && instr == '0)); // R4

    AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (rst)
        stall |=> ($stable(instr) && $stable(instr_pc) && $stable(instr_valid) && !cread_valid)); // R6

    AST_CONST_BUBBLE: assert property (@(posedge clk) disable iff (rst)
        cread_valid |-> !instr_valid); // R7

    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(instr_valid) && !$past(stall) && instr_valid)
            |-> (instr_pc == PC_W'($past(instr_pc) + PC_W'(1)))); // R2
endmodule

bind pfetch_unit pfetch_unit_chk #(
    .PC_W(PC_W), .INSTR_W(INSTR_W), .OFS_W(OFS_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .stall       (stall),
    .redir_req   (redir_req),
    .redir_ofs   (redir_ofs),
    .imem_addr   (imem_addr),
    .instr       (instr),
    .instr_pc    (instr_pc),
    .instr_valid (instr_valid),
    .cread_valid (cread_valid)
);

// File: tb/pfetch_unit_tb.sv
module pfetch_unit_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        stall;
    logic        redir_req;
    logic [11:0] redir_ofs;
    logic        cread_req;
    logic [15:0] cread_ptr;
    logic [15:0] imem_rdata;
    logic [8:0]  imem_addr;
    logic [15:0] instr;
    logic [8:0]  instr_pc;
    logic        instr_valid;
    logic [7:0]  cread_data;
    logic        cread_valid;

    int checks = 0;
    int fails  = 0;
    int cur    = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    pfetch_unit u_dut (
        .clk(clk), .rst(rst), .stall(stall), .redir_req(redir_req),
        .redir_ofs(redir_ofs), .cread_req(cread_req), .cread_ptr(cread_ptr),
        .imem_rdata(imem_rdata), .imem_addr(imem_addr), .instr(instr),
        .instr_pc(instr_pc), .instr_valid(instr_valid),
        .cread_data(cread_data), .cread_valid(cread_valid)
    );

    function automatic logic [15:0] word_of(input logic [8:0] a);
        return 16'({7'd0, a} * 16'd40503) ^ 16'h5A3C;
    endfunction

    always_ff @(posedge clk) imem_rdata <= word_of(imem_addr);

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic expect_ir(input bit v, input int pc, input string tag);
        if (v) begin
            check(instr_valid == 1'b1, {tag, " valid"}, int'(instr_valid), 1);
            check(instr_pc == 9'(pc), {tag, " pc"}, int'(instr_pc), pc % 512);
            check(instr == word_of(9'(pc)), {tag, " word"}, int'(instr), int'(word_of(9'(pc))));
        end else begin
            check(instr_valid == 1'b0, {tag, " nop valid"}, int'(instr_valid), 0);
            check(instr == 16'h0000, {tag, " nop word"}, int'(instr), 0);
        end
    endtask

    function automatic int wrap(input int v);
        return ((v % 512) + 512) % 512;
    endfunction

    task automatic t_reset();
        rst = 1'b1; stall = 0; redir_req = 0; redir_ofs = 0; cread_req = 0; cread_ptr = 0;
        repeat (3) step();
        check(instr_valid == 0, "R1 reset instr_valid", int'(instr_valid), 0);
        check(cread_valid == 0, "R1 reset cread_valid", int'(cread_valid), 0);
        check(imem_addr == 0, "R1 reset addr", int'(imem_addr), 0);
        rst = 1'b0;
        step();
        expect_ir(0, 0, "R1 first word dropped");
        step();
        expect_ir(1, 0, "R1 first valid");
        for (int i = 1; i <= 5; i++) begin
            step();
            expect_ir(1, i, "R2 sequential");
        end
        cur = 5;
    endtask

    task automatic t_redir(input int o);
        int tgt;
        tgt = wrap(cur + o + 1);
        redir_req = 1; redir_ofs = 12'(o);
        #1;
        check(imem_addr == 9'(tgt), "R3 target addr", int'(imem_addr), tgt);
        step();
        redir_req = 0;
        expect_ir(0, 0, "R4 squash");
        step();
        expect_ir(1, tgt, "R3 target instr");
        step();
        expect_ir(1, wrap(tgt + 1), "R2 after target");
        cur = wrap(tgt + 1);
    endtask

    task automatic t_wrap();
        t_redir(508 - cur - 1);
        for (int i = 0; i < 4; i++) begin
            step();
            cur = wrap(cur + 1);
            expect_ir(1, cur, "R2 wrap 511 to 0");
        end
    endtask

    task automatic t_redir_ignored();
        int tgt;
        tgt = wrap(cur + 40 + 1);
        redir_req = 1; redir_ofs = 12'd40;
        step();
        redir_ofs = 12'd100;           // still requested during the no-op slot
        expect_ir(0, 0, "R4 squash");
        step();
        redir_req = 0;
        expect_ir(1, tgt, "R5 redirect in nop ignored");
        step();
        expect_ir(1, wrap(tgt + 1), "R5 stream continues");
        cur = wrap(tgt + 1);
    endtask

    task automatic t_stall();
        stall = 1;
        for (int i = 0; i < 3; i++) begin
            step();
            expect_ir(1, cur, "R6 stall hold");
            check(cread_valid == 0, "R6 stall strobe", int'(cread_valid), 0);
        end
        redir_req = 1; redir_ofs = 12'd7; cread_req = 1; cread_ptr = 16'h0010;
        step();
        expect_ir(1, cur, "R6 stall with requests");
        stall = 0; redir_req = 0; cread_req = 0;
        step();
        expect_ir(1, wrap(cur + 1), "R6 resume");
        check(cread_valid == 0, "R6 cread ignored", int'(cread_valid), 0);
        step();
        expect_ir(1, wrap(cur + 2), "R6 no redirect taken");
        check(cread_valid == 0, "R6 cread ignored late", int'(cread_valid), 0);
        cur = wrap(cur + 2);
    endtask

    task automatic t_cread(input logic [15:0] ptr, input string tag);
        logic [15:0] w;
        logic [7:0]  eb;
        w  = word_of(ptr[9:1]);
        eb = (ptr[15:10] != 0) ? 8'h00 : (ptr[0] ? w[15:8] : w[7:0]);
        cread_req = 1; cread_ptr = ptr;
        #1;
        check(imem_addr == ptr[9:1], {tag, " addr"}, int'(imem_addr), int'(ptr[9:1]));
        step();
        cread_req = 0;
        expect_ir(1, wrap(cur + 1), "R7 next instr");
        check(cread_valid == 0, {tag, " early strobe"}, int'(cread_valid), 0);
        step();
        check(cread_valid == 1, {tag, " strobe"}, int'(cread_valid), 1);
        check(cread_data == eb, {tag, " data"}, int'(cread_data), int'(eb));
        expect_ir(0, 0, "R7 bubble");
        step();
        check(cread_valid == 0, {tag, " strobe one cycle"}, int'(cread_valid), 0);
        expect_ir(1, wrap(cur + 2), "R7 pc held");
        cur = wrap(cur + 2);
    endtask

    task automatic t_cread_vs_redir();
        int tgt;
        tgt = wrap(cur + 3 + 1);
        redir_req = 1; redir_ofs = 12'd3; cread_req = 1; cread_ptr = 16'h0021;
        step();
        redir_req = 0; cread_req = 0;
        expect_ir(0, 0, "R9 squash");
        check(cread_valid == 0, "R9 no strobe a", int'(cread_valid), 0);
        step();
        expect_ir(1, tgt, "R9 redirect wins");
        check(cread_valid == 0, "R9 no strobe b", int'(cread_valid), 0);
        step();
        expect_ir(1, wrap(tgt + 1), "R9 stream");
        check(cread_valid == 0, "R9 no strobe c", int'(cread_valid), 0);
        cur = wrap(tgt + 1);
    endtask

    initial begin
        t_reset();
        t_redir(5);
        t_redir(-1);
        t_redir(-2048);
        t_redir(2047);
        t_wrap();
        t_redir_ignored();
        t_stall();
        t_cread(16'h0006, "R7 low byte");
        t_cread(16'h0007, "R7 high byte");
        t_cread(16'h03FF, "R7 last byte");
        t_cread(16'h8404, "R8 out of range");
        t_cread_vs_redir();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule